// File: doc/BRIEF.md
# Hot-Plug Slot Status and Interrupt Register Bank

This block is the register bank that sits behind a byte-wide management bus slave. Only single-byte reads and single-byte writes reach it. The bus framing layer decodes each transaction into a register address, a write strobe and a write byte. The block returns the addressed byte combinationally on a read-data port. It does not answer alert-response cycles.

Each power slot has two registers. The first is a control register. It holds the two slot enable bits and a bit that blocks the slot's forced-on override input. The second is a status register. The protection logic raises fault pulses, and the status register captures each one in a sticky bit. Software clears a sticky bit by writing a 1 to its position. One common status register holds a sticky die-overtemperature bit at bit 0. It also shows the live levels of two general-purpose input pins at bits [5:4].

An interrupt mask register decides which sticky groups may drive the active-low interrupt output. The interrupt is only raised while the management interface is marked active. A two-state machine drives the interrupt pin:
- `IRQ_IDLE` moves to `IRQ_ASSERTED` on the transition RAISE, when an unmasked sticky bit is set while the interface is active.
- `IRQ_ASSERTED` returns to `IRQ_IDLE` on the transition RELEASE, when no such bit remains.

The register map is as follows:
- Slot s control register: address 2·s.
- Slot s status register: address 2·s+1.
- Common status register: address 2·NUM_SLOTS.
- Mask register: address 2·NUM_SLOTS+1.

Top module: `mgmt_status_regfile`

## Requirements
- R1: After reset, every register reads 0x00, all slot enables and override blocks are 0, and `irq_n` is 1.
- R2: A slot control register stores write bits [2:0]. Bits [1:0] drive that slot's two enables, bit [2] drives its override block, and bits [7:3] read 0.
- R3: A fault pulse on bit k of a slot's event vector sets bit k of that slot's status register (bits [3:0]). The bit stays set with no further pulse.
- R4: Writing 1 to a set status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R5: When a fault pulse and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R6: Common status bits [5:4] show the current levels of `gpi_pins[1:0]`, and writes do not change them.
- R7: A die-overtemperature pulse sets common status bit 0. This bit is sticky and clears when 1 is written to it.
- R8: `irq_n` goes low on the second clock edge after an unmasked sticky bit becomes set, and only while `mgmt_active` is 1. While `mgmt_active` is 0, `irq_n` stays 1.
- R9: Mask bit s (1 = masked) blocks slot s status bits from the interrupt. Mask bit NUM_SLOTS blocks the overtemperature bit. The mask register is read/write.
- R10: `irq_n` returns to 1 one clock edge after the last unmasked sticky bit is cleared.
- R11: Addresses outside the map read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per byte write |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte for `reg_addr` |
| slot_fault_evt | input | NUM_SLOTS*EVT_W | Fault pulses, EVT_W bits per slot |
| die_ot_evt | input | 1 | Die overtemperature pulse |
| gpi_pins | input | 2 | General-purpose input levels |
| mgmt_active | input | 1 | Management interface in use |
| slot_enable | output | 2*NUM_SLOTS | Two enables per slot |
| force_on_block | output | NUM_SLOTS | Override-input block per slot |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is a fault pulse that lands in the same clock cycle as a write-1-to-clear of the same bit. The bench drives the event vector and the write strobe on the same falling edge, so both are seen on one rising edge. It also has to show that a masked group stays silent while another group raises the interrupt. To do this, it sets one slot's mask, faults both slots one after the other, and watches `irq_n` at the exact edge where each change is expected. It then clears the unmasked slot and unmasks the other, and checks that the interrupt drops again exactly one edge later.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int CTRL_W  = 3;
    localparam int GPI_W   = 2;
    localparam int GPI_LSB = 4;
    localparam int OT_BIT  = 0;

    typedef enum logic [0:0] {
        IRQ_IDLE     = 1'b0,
        IRQ_ASSERTED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/msr_slot_regs.sv
module msr_slot_regs
    import msr_pkg::*;
#(
    parameter int EVT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              stat_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [EVT_W-1:0]  evt,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [EVT_W-1:0]  stat_q
);
    logic [EVT_W-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (stat_we) clr_mask = wdata[EVT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= wdata[CTRL_W-1:0];
        end
    end

    // event set has priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | evt;
        end
    end

    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(ctrl_q));

    p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/msr_common_regs.sv
module msr_common_regs
    import msr_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 com_we,
    input  logic                 mask_we,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 die_ot_evt,
    output logic                 ot_q,
    output logic [NUM_SLOTS:0]   mask_q
);
    localparam int MASK_W = NUM_SLOTS + 1;

    logic ot_clr;

    assign ot_clr = com_we & wdata[OT_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ot_q <= 1'b0;
        end else begin
            ot_q <= (ot_q & ~ot_clr) | die_ot_evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wdata[MASK_W-1:0];
        end
    end

    p_ot_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        die_ot_evt |=> ot_q);

    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/msr_irq_fsm.sv
module msr_irq_fsm
    import msr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq_n
);
    irq_state_t state_q;
    irq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:     if (pending)  state_d = IRQ_ASSERTED; // RAISE
            IRQ_ASSERTED: if (!pending) state_d = IRQ_IDLE;     // RELEASE
            default:      state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_ASSERTED: irq_n = 1'b0;
            default:      irq_n = 1'b1;
        endcase
    end

    p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> !irq_n);

    p_irq_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> irq_n);
endmodule

// File: rtl/mgmt_status_regfile.sv
module mgmt_status_regfile
    import msr_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int EVT_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_wr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    input  logic [NUM_SLOTS*EVT_W-1:0] slot_fault_evt,
    input  logic                       die_ot_evt,
    input  logic [GPI_W-1:0]           gpi_pins,
    input  logic                       mgmt_active,
    output logic [2*NUM_SLOTS-1:0]     slot_enable,
    output logic [NUM_SLOTS-1:0]       force_on_block,
    output logic                       irq_n
);
    localparam logic [ADDR_W-1:0] COM_ADDR  = ADDR_W'(2 * NUM_SLOTS);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(2 * NUM_SLOTS + 1);

    logic [CTRL_W-1:0] ctrl_q [NUM_SLOTS];
    logic [EVT_W-1:0]  stat_q [NUM_SLOTS];
    logic              ot_q;
    logic [NUM_SLOTS:0] mask_q;
    logic              pending;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * s);
        localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(2 * s + 1);

        logic ctrl_we;
        logic stat_we;

        assign ctrl_we = reg_wr && (reg_addr == CTRL_ADDR);
        assign stat_we = reg_wr && (reg_addr == STAT_ADDR);

        msr_slot_regs #(.EVT_W(EVT_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl_we(ctrl_we),
            .stat_we(stat_we),
            .wdata  (reg_wdata),
            .evt    (slot_fault_evt[s*EVT_W +: EVT_W]),
            .ctrl_q (ctrl_q[s]),
            .stat_q (stat_q[s])
        );

        assign slot_enable[2*s +: 2] = ctrl_q[s][1:0];
        assign force_on_block[s]     = ctrl_q[s][2];
    end

    msr_common_regs #(.NUM_SLOTS(NUM_SLOTS)) u_common (
        .clk       (clk),
        .rst_n     (rst_n),
        .com_we    (reg_wr && (reg_addr == COM_ADDR)),
        .mask_we   (reg_wr && (reg_addr == MASK_ADDR)),
        .wdata     (reg_wdata),
        .die_ot_evt(die_ot_evt),
        .ot_q      (ot_q),
        .mask_q    (mask_q)
    );

    // read mux; unmapped addresses return zero (R11)
    always_comb begin
        reg_rdata = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (reg_addr == ADDR_W'(2 * s))     reg_rdata[CTRL_W-1:0] = ctrl_q[s];
            if (reg_addr == ADDR_W'(2 * s + 1)) reg_rdata[EVT_W-1:0]  = stat_q[s];
        end
        if (reg_addr == COM_ADDR) begin
            reg_rdata[OT_BIT]                = ot_q;
            reg_rdata[GPI_LSB +: GPI_W]      = gpi_pins;
        end
        if (reg_addr == MASK_ADDR) reg_rdata[NUM_SLOTS:0] = mask_q;
    end

    always_comb begin
        pending = ot_q & ~mask_q[NUM_SLOTS];
        for (int s = 0; s < NUM_SLOTS; s++) begin
            pending = pending | ((|stat_q[s]) & ~mask_q[s]);
        end
        pending = pending & mgmt_active;
    end

    msr_irq_fsm u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pending(pending),
        .irq_n  (irq_n)
    );
endmodule

// File: tb/sim_mgmt_status_regfile.sv
module sim_mgmt_status_regfile;
    localparam int NS = 2;
    localparam int EW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NS*EW-1:0] slot_fault_evt = '0;
    logic          die_ot_evt = 1'b0;
    logic [1:0]    gpi_pins = 2'b00;
    logic          mgmt_active = 1'b0;
    logic [2*NS-1:0] slot_enable;
    logic [NS-1:0] force_on_block;
    logic          irq_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    mgmt_status_regfile #(.NUM_SLOTS(NS), .EVT_W(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .slot_fault_evt(slot_fault_evt), .die_ot_evt(die_ot_evt),
        .gpi_pins(gpi_pins), .mgmt_active(mgmt_active),
        .slot_enable(slot_enable), .force_on_block(force_on_block),
        .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input int slot, input logic [EW-1:0] bits);
        @(negedge clk);
        slot_fault_evt[slot*EW +: EW] = bits;
        @(negedge clk);
        slot_fault_evt = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 6; a++) begin
            rd(8'(a), d); chk("R1 reg", d, 8'h00);
        end
        chk("R1 enables", {4'h0, slot_enable}, 8'h00);
        chk("R1 block", {6'h0, force_on_block}, 8'h00);
        chk("R1 irq", {7'h0, irq_n}, 8'h01);
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        wr(8'h00, 8'hFF); rd(8'h00, d); chk("R2 ctrl0", d, 8'h07);
        wr(8'h02, 8'h05); rd(8'h02, d); chk("R2 ctrl1", d, 8'h05);
        chk("R2 enables", {4'h0, slot_enable}, 8'h07);
        chk("R2 block", {6'h0, force_on_block}, 8'h03);
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        pulse(0, 4'h4);
        rd(8'h01, d); chk("R3 set", d, 8'h04);
        repeat (3) @(negedge clk);
        rd(8'h01, d); chk("R3 hold", d, 8'h04);
        wr(8'h01, 8'h00); rd(8'h01, d); chk("R4 zero write", d, 8'h04);
        wr(8'h01, 8'h04); rd(8'h01, d); chk("R4 clear", d, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        @(negedge clk);
        reg_addr = 8'h03; reg_wdata = 8'h02; reg_wr = 1'b1;
        slot_fault_evt[EW +: EW] = 4'h2;
        @(negedge clk);
        reg_wr = 1'b0; slot_fault_evt = '0;
        rd(8'h03, d); chk("R5 event wins", d, 8'h02);
        wr(8'h03, 8'h02); rd(8'h03, d); chk("R5 later clear", d, 8'h00);
    endtask

    task automatic t_gpi_ot();
        logic [7:0] d;
        gpi_pins = 2'b10; rd(8'h04, d); chk("R6 gpi 10", d, 8'h20);
        gpi_pins = 2'b01; rd(8'h04, d); chk("R6 gpi 01", d, 8'h10);
        wr(8'h04, 8'hFE); rd(8'h04, d); chk("R6 write ignored", d, 8'h10);
        @(negedge clk); die_ot_evt = 1'b1;
        @(negedge clk); die_ot_evt = 1'b0;
        rd(8'h04, d); chk("R7 ot set", d, 8'h11);
        wr(8'h04, 8'h01); rd(8'h04, d); chk("R7 ot clear", d, 8'h10);
    endtask

    task automatic t_irq();
        mgmt_active = 1'b1;
        @(negedge clk); slot_fault_evt[EW +: EW] = 4'h1;
        @(negedge clk); slot_fault_evt = '0;
        chk("R8 one edge", {7'h0, irq_n}, 8'h01);
        @(negedge clk);
        chk("R8 two edges", {7'h0, irq_n}, 8'h00);
        @(negedge clk); reg_addr = 8'h03; reg_wdata = 8'h01; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        chk("R10 still low", {7'h0, irq_n}, 8'h00);
        @(negedge clk);
        chk("R10 released", {7'h0, irq_n}, 8'h01);
    endtask

    task automatic t_mgmt_off();
        mgmt_active = 1'b0;
        pulse(0, 4'h1);
        repeat (3) @(negedge clk);
        chk("R8 inactive", {7'h0, irq_n}, 8'h01);
        mgmt_active = 1'b1;
        @(negedge clk);
        chk("R8 activated", {7'h0, irq_n}, 8'h00);
        wr(8'h01, 8'h01);
        @(negedge clk);
        chk("R10 after clear", {7'h0, irq_n}, 8'h01);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        wr(8'h05, 8'h01); rd(8'h05, d); chk("R9 mask rw", d, 8'h01);
        pulse(0, 4'h8);
        repeat (3) @(negedge clk);
        chk("R9 masked slot", {7'h0, irq_n}, 8'h01);
        pulse(1, 4'h2);
        @(negedge clk);
        chk("R9 unmasked slot", {7'h0, irq_n}, 8'h00);
        wr(8'h03, 8'h02);
        @(negedge clk);
        chk("R9 masked left", {7'h0, irq_n}, 8'h01);
        wr(8'h05, 8'h00);
        @(negedge clk);
        chk("R9 unmask", {7'h0, irq_n}, 8'h00);
        wr(8'h01, 8'h08);
        @(negedge clk);
        wr(8'h05, 8'h04);
        @(negedge clk); die_ot_evt = 1'b1;
        @(negedge clk); die_ot_evt = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 ot masked", {7'h0, irq_n}, 8'h01);
        rd(8'h04, d); chk("R9 ot captured", d, 8'h11);
        wr(8'h04, 8'h01); wr(8'h05, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        wr(8'h20, 8'hFF); rd(8'h20, d); chk("R11 far", d, 8'h00);
        wr(8'h06, 8'hFF); rd(8'h06, d); chk("R11 next", d, 8'h00);
        rd(8'h00, d); chk("R11 ctrl0 kept", d, 8'h07);
        rd(8'h05, d); chk("R11 mask kept", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_sticky();
        t_collide();
        t_gpi_ot();
        t_irq();
        t_mgmt_off();
        t_mask();
        t_unmapped();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule